// File: doc/BRIEF.md
# Per-Lane Variable Shift Unit for 128-bit Vectors

This block shifts every lane of a 128-bit data vector by its own signed distance. The distance for each lane is taken from the same lane of a second vector. A positive distance moves bits left and a negative distance moves them right. Five control inputs set the lane width, signed or unsigned arithmetic, round-to-nearest on right shifts, clamping of left shifts that overflow, and a scalar form in which only the lowest lane is computed.

The lane arithmetic is combinational, and a parameter can place a register after it. A sticky flag records that some active lane was clamped. The flag holds until software-visible logic clears it through a dedicated input. Out-of-range distances give well-defined results, so no distance between -128 and +127 needs special handling by the caller.

Top module: `vshift_lane_unit`

## Requirements
- R1: `lane_sz` selects the lane width as 8 << `lane_sz` (code 0=8, 1=16, 2=32, 3=64 bits), which gives 16, 8, 4 or 2 lanes. Lane i of `src_a` occupies bits [i*W +: W]. Its distance is bits [i*W +: 8] of `src_b`, read as a two's-complement byte.
- R2: A distance of zero returns the lane unchanged. A positive distance shifts left with zero fill. Without clamping, a left distance equal to or above the lane width gives zero.
- R3: A negative distance shifts right by its magnitude. The shift is arithmetic when `sgn_mode`=1 and logical otherwise. A right distance equal to or above the width gives all ones for a negative signed lane and zero in every other case.
- R4: With `rnd_mode`=1, a right shift by n returns floor((x + 2^(n-1)) / 2^n), computed without losing the carry, including for 64-bit lanes. Signed lanes give 0 for n equal to or above the width. For an unsigned 64-bit lane 0x8000000000000000 shifted by 64, the result is 1.
- R5: With `sat_mode`=1, a left shift whose value does not fit the lane returns the signed maximum or minimum (chosen by the sign of the input) or the unsigned maximum. A nonzero lane shifted by the width or more always clamps, and a zero lane never does. Right shifts never clamp.
- R6: With `scalar_mode`=1, only lane 0 is computed. All result bits above lane 0 are zero, and upper lanes cannot clamp.
- R7: `sat_flag` rises at the clock edge after any cycle in which an active lane clamps. It stays high until `sat_clr` is high in a cycle with no clamping lane. When a clear and a new clamp arrive in the same cycle, the flag stays high.
- R8: With the default `OUT_REG`=1, `result` changes at the first rising clock edge after its inputs change. Reset (`rst_n` low) forces `result` and `sat_flag` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_a | input | 128 | Data lanes to shift |
| src_b | input | 128 | Per-lane signed distance in the low byte of each lane |
| lane_sz | input | 2 | Lane width code |
| sgn_mode | input | 1 | Signed lane arithmetic |
| rnd_mode | input | 1 | Round on right shifts |
| sat_mode | input | 1 | Clamp overflowing left shifts |
| scalar_mode | input | 1 | Compute lane 0 only |
| sat_clr | input | 1 | Clear the sticky clamp flag |
| result | output | 128 | Shifted lanes |
| sat_flag | output | 1 | Sticky clamp indication |

## Verification
The two functions that can meet in one cycle are clearing the sticky flag and a lane clamping again. The bench raises `sat_clr` while the inputs hold a lane that overflows, and expects the flag to stay high. It then clears again with harmless inputs and expects the flag to drop. A second overlap occurs when rounding and clamping are both enabled on a right shift: the bench checks that the rounded value appears and that the flag stays low.

// File: rtl/vshift_lane_unit.sv
module vshift_lane_unit #(
  parameter int VW      = 128,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] src_a,
  input  logic [VW-1:0] src_b,
  input  logic [1:0]    lane_sz,
  input  logic          sgn_mode,
  input  logic          rnd_mode,
  input  logic          sat_mode,
  input  logic          scalar_mode,
  input  logic          sat_clr,
  output logic [VW-1:0] result,
  output logic          sat_flag
);

  // returns {clamped, lane_result}
  function automatic logic [64:0] lane_op(input logic [63:0] d, input logic [7:0] amt,
                                          input logic [6:0] w, input logic sg,
                                          input logic rnd, input logic sat);
    logic [64:0]         m65;
    logic [63:0]         mask, xu, res;
    logic                neg, ovf;
    logic signed [67:0]  xs, rc, sum, sh;
    logic signed [127:0] wide, tops;
    logic [7:0]          mag;
    m65  = (65'd1 << w) - 65'd1;
    mask = m65[63:0];
    xu   = d & mask;
    neg  = sg & d[w-7'd1];
    xs   = neg ? $signed({4'hF, xu | ~mask}) : $signed({4'h0, xu});
    ovf  = 1'b0;
    res  = xu;
    wide = '0;
    if (amt[7]) begin
      mag = 8'd0 - amt;
      if (mag > 8'd66) mag = 8'd66;
      rc  = rnd ? (68'sd1 <<< (mag - 8'd1)) : 68'sd0;
      sum = xs + rc;
      sh  = sum >>> mag;
      res = sh[63:0] & mask;
    end else if (amt != 8'd0) begin
      if (!sat) begin
        res = (xu << amt) & mask;
      end else begin
        if (amt >= {1'b0, w}) begin
          ovf = (xu != 64'd0);
        end else begin
          wide = 128'(xs);
          wide = wide <<< amt;
          tops = wide >>> (w - 7'd1);
          if (sg) ovf = !((tops == 128'sd0) || (tops == -128'sd1));
          else    ovf = ((wide >> w) != 128'sd0);
        end
        if (ovf) begin
          if (sg) res = neg ? (64'd1 << (w - 7'd1)) : (mask >> 1);
          else    res = mask;
        end else begin
          res = wide[63:0] & mask;
        end
      end
    end
    return {ovf, res};
  endfunction

  logic [VW-1:0] nxt;
  logic [3:0]    sz_ovf;

  for (genvar s = 0; s < 4; s++) begin : g_sz
    localparam int W  = 8 << s;
    localparam int NL = VW / W;
    logic [VW-1:0] res;
    logic [NL-1:0] ovf;
    for (genvar i = 0; i < NL; i++) begin : g_ln
      logic [64:0] r;
      logic        idle;
      assign idle = scalar_mode && (i != 0);
      assign r = lane_op(64'(src_a[i*W +: W]), src_b[i*W +: 8], 7'(W),
                         sgn_mode, rnd_mode, sat_mode);
      assign res[i*W +: W] = idle ? '0 : r[W-1:0];
      assign ovf[i] = r[64] && !idle;
    end
    assign sz_ovf[s] = |ovf;
  end

  always_comb begin
    case (lane_sz)
      2'd0:    nxt = g_sz[0].res;
      2'd1:    nxt = g_sz[1].res;
      2'd2:    nxt = g_sz[2].res;
      default: nxt = g_sz[3].res;
    endcase
  end

  logic any_sat;
  assign any_sat = sz_ovf[lane_sz];

  if (OUT_REG) begin : g_oreg
    always_ff @(posedge clk) begin
      if (!rst_n) result <= '0;
      else        result <= nxt;
    end

    AST_ZERO_AMT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (!scalar_mode && lane_sz == 2'd3 && src_b[7:0] == 8'd0 && src_b[71:64] == 8'd0)
      |=> result == $past(src_a)); // R2
    AST_SCALAR_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (scalar_mode && lane_sz == 2'd0) |=> result[VW-1:8] == '0); // R6
  end else begin : g_ocomb
    always_comb result = nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sat_flag <= 1'b0;
    else        sat_flag <= (sat_flag & ~sat_clr) | any_sat;
  end

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_flag && !sat_clr) |=> sat_flag); // R7
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    any_sat |=> sat_flag); // R7
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_clr && !any_sat) |=> !sat_flag); // R7
  AST_NO_CLAMP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !sat_mode |-> !any_sat); // R5
  AST_RIGHT_NO_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_sz == 2'd3 && src_b[7] && src_b[71]) |-> !any_sat); // R5

endmodule

// File: tb/vshift_lane_unit_test.sv
module vshift_lane_unit_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] a = '0, b = '0;
  logic [1:0]   sz = 2'd0;
  logic         sg = 1'b0, rnd = 1'b0, sat = 1'b0, sc = 1'b0, clr = 1'b0;
  logic [127:0] result;
  logic         sat_flag;
  int           n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  vshift_lane_unit uut (
    .clk(clk), .rst_n(rst_n), .src_a(a), .src_b(b), .lane_sz(sz),
    .sgn_mode(sg), .rnd_mode(rnd), .sat_mode(sat), .scalar_mode(sc),
    .sat_clr(clr), .result(result), .sat_flag(sat_flag)
  );

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [127:0] ia, input logic [127:0] ib, input logic [1:0] isz,
                       input logic isg, input logic irnd, input logic isat, input logic isc);
    @(negedge clk);
    a = ia; b = ib; sz = isz; sg = isg; rnd = irnd; sat = isat; sc = isc;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk);
    a = '0; b = '0; sat = 1'b0; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R8 reset result", result, '0);
    chk("R8 reset flag", 128'(sat_flag), 128'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_sizes();
    apply({16{8'h01}}, 128'h0F0E0D0C0B0A09080706050403020100, 2'd0, 0, 0, 0, 0);
    chk("R1 R2 byte lanes left", result, 128'h00000000000000008040201008040201);
  endtask

  task automatic t_right();
    apply({8{16'h8000}}, 128'h0080_00F0_00F1_00FF, 2'd1, 1, 0, 0, 0);
    chk("R3 signed right", result, 128'h8000_8000_8000_8000_FFFF_FFFF_FFFF_C000);
    apply({8{16'h8000}}, 128'h0080_00F0_00F1_00FF, 2'd1, 0, 0, 0, 0);
    chk("R3 unsigned right", result, 128'h8000_8000_8000_8000_0000_0000_0001_4000);
  endtask

  task automatic t_round();
    apply(128'h80000000_7FFFFFFF_FFFFFFFB_00000005, 128'h000000E0_000000E0_000000FF_000000FF,
          2'd2, 1, 1, 0, 0);
    chk("R4 round 32 signed", result, 128'h00000000_00000000_FFFFFFFE_00000003);
    apply({64'h8000000000000000, 64'hFFFFFFFFFFFFFFFF}, {64'hC0, 64'hFF}, 2'd3, 0, 1, 0, 0);
    chk("R4 round 64 unsigned carry", result, {64'h1, 64'h8000000000000000});
    apply({64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF}, {64'hC1, 64'hFF}, 2'd3, 1, 1, 0, 0);
    chk("R4 round 64 signed carry", result, {64'hFFFFFFFFFFFFFFFF, 64'h4000000000000000});
  endtask

  task automatic t_sat();
    clear_flag();
    chk("R7 flag cleared", 128'(sat_flag), 128'd0);
    apply({64'h0, 64'h00FF0001BFC02040}, {64'h0, 64'h007F640801010101}, 2'd0, 1, 0, 1, 0);
    chk("R5 signed byte clamp", result, {64'h0, 64'h0080007F8080407F});
    chk("R7 flag set", 128'(sat_flag), 128'd1);
    clear_flag();
    apply({96'h0, 32'h01017F80}, {96'h0, 32'h08070101}, 2'd0, 0, 0, 1, 0);
    chk("R5 unsigned byte clamp", result, {96'h0, 32'hFF80FEFF});
    apply({64'hC000000000000000, 64'h4000000000000000}, {64'h1, 64'h1}, 2'd3, 1, 0, 1, 0);
    chk("R5 signed 64 clamp", result, {64'h8000000000000000, 64'h7FFFFFFFFFFFFFFF});
    clear_flag();
    apply({8{16'h7FFF}}, {8{16'h00FF}}, 2'd1, 1, 1, 1, 0);
    chk("R5 right with clamp on", result, {8{16'h4000}});
    chk("R5 right never flags", 128'(sat_flag), 128'd0);
  endtask

  task automatic t_scalar();
    apply({64'h1111111111111111, 64'h3}, {64'h1, 64'hFF}, 2'd3, 0, 0, 0, 1);
    chk("R6 scalar 64", result, {64'h0, 64'h1});
    apply({{15{8'h40}}, 8'h81}, {{15{8'h01}}, 8'h01}, 2'd0, 1, 0, 0, 1);
    chk("R6 scalar byte", result, 128'h02);
    apply({{15{8'h40}}, 8'h01}, {{15{8'h01}}, 8'h01}, 2'd0, 1, 0, 1, 1);
    chk("R6 scalar upper lanes no clamp", 128'(sat_flag), 128'd0);
  endtask

  task automatic t_sticky();
    apply({120'h0, 8'h40}, {120'h0, 8'h01}, 2'd0, 1, 0, 1, 0);
    chk("R7 set", 128'(sat_flag), 128'd1);
    apply('0, '0, 2'd0, 0, 0, 0, 0);
    apply({16{8'h01}}, '0, 2'd0, 0, 0, 1, 0);
    chk("R7 sticky holds", 128'(sat_flag), 128'd1);
    @(negedge clk);
    a = {120'h0, 8'h40}; b = {120'h0, 8'h01}; sg = 1'b1; sat = 1'b1; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    chk("R7 clear with clamp same cycle", 128'(sat_flag), 128'd1);
    clear_flag();
    chk("R7 clear alone", 128'(sat_flag), 128'd0);
  endtask

  task automatic t_latency();
    apply({16{8'h03}}, '0, 2'd0, 0, 0, 0, 0);
    @(negedge clk);
    a = {16{8'h05}};
    #2;
    chk("R8 no change before edge", result, {16{8'h03}});
    @(negedge clk);
    chk("R8 update after edge", result, {16{8'h05}});
  endtask

  initial begin
    t_reset();
    t_sizes();
    t_right();
    t_round();
    t_sat();
    t_scalar();
    t_sticky();
    t_latency();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule